// File: doc/BRIEF.md
# Timer Interrupt Flag and Mask Unit

This block collects event pulses from two timers and turns them into interrupt requests for a CPU. Four sources are tracked: counter 1 input capture, counter 1 compare match, counter 1 overflow and counter 0 overflow. Each source has a sticky flag and an enable bit. Software reaches both registers over a simple I/O register bus.

A flag is set by a one-cycle pulse from its timer. Software clears a flag by writing a one to its bit. The flag is also cleared when the CPU acknowledges the vector that belongs to it. In PWM mode the counter 1 overflow flag takes its set pulse from a separate input, which marks counter 1 turning around at zero. The wrap pulse is not used in that mode.

A source raises a request only while its flag, its enable bit and the global interrupt-enable input are all high. The request and its vector number leave the block from registers. When several sources are pending at once, the lowest vector number is presented first.

Top module: `tmr_irq_unit`

## Requirements
- R1: After reset, both registers read 0x00, `irq_req` is 0 and `irq_vec` is 0.
- R2: The enable register sits at I/O address 0x39. It stores written bits 7 (counter 1 overflow), 6 (compare match), 3 (input capture) and 1 (counter 0 overflow). Bits 5, 4, 2 and 0 always read 0, and writes to them are ignored.
- R3: The flag register sits at I/O address 0x38 and uses the same bit positions as the enable register. A one-cycle event pulse sets its flag on the next clock edge. Reserved bits read 0, and writing a zero to a flag bit leaves it unchanged.
- R4: Writing a one to a flag bit at 0x38 clears that flag, and only that flag.
- R5: An acknowledge (`ack_valid` high) clears only the flag whose vector equals `ack_vec`. An acknowledge of any other value changes no flag.
- R6: A source requests an interrupt only when its flag, its enable bit and `gie` are all 1.
- R7: The vector numbers are fixed: 3 for input capture, 4 for compare match, 5 for counter 1 overflow and 6 for counter 0 overflow.
- R8: With `pwm_mode` high, the counter 1 overflow flag is set by `ev_turn1` and `ev_ovf1` is ignored. With `pwm_mode` low, the roles are swapped.
- R9: When several sources are requesting, `irq_vec` shows the lowest pending vector number.
- R10: If a set pulse arrives in the same cycle as a write-one clear or an acknowledge for that flag, the flag ends up set.
- R11: `irq_req` and `irq_vec` are registered. They reflect the flags, enables and `gie` of the previous cycle. `irq_vec` is 0 whenever `irq_req` is 0.
- R12: Reads of any other I/O address return 0x00, and writes to other addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 6 | I/O register address |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for `io_addr` (combinational) |
| ev_cap1 | input | 1 | Counter 1 input capture pulse |
| ev_cmp1 | input | 1 | Counter 1 compare match pulse |
| ev_ovf1 | input | 1 | Counter 1 wrap pulse |
| ev_turn1 | input | 1 | Counter 1 turn-at-zero pulse (PWM) |
| ev_ovf0 | input | 1 | Counter 0 overflow pulse |
| pwm_mode | input | 1 | Selects the counter 1 overflow set source |
| gie | input | 1 | Global interrupt enable |
| ack_valid | input | 1 | CPU acknowledge strobe |
| ack_vec | input | 3 | Acknowledged vector number |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | 3 | Vector number of the presented request |

## Verification
A flag that is wrongly held or lost shows up at `io_rdata` in the same cycle that the flag address is read. With its enable and `gie` high, it also shows up at `irq_req`/`irq_vec` one cycle after the flag register changes. A corrupted enable bit shows the same way, on a read of 0x39 and on the next request cycle. A wrong priority or a wrong vector number appears on `irq_vec` in the cycle after two sources become pending together. The bench compares all outputs against a behavioural model on every cycle, so a divergence is reported within one clock of its cause.

// File: rtl/tirq_pkg.sv
package tirq_pkg;
  localparam int NSRC = 4;
  localparam int DW   = 8;
  localparam int AW   = 6;
  localparam int VW   = 3;
  // source index order is vector order: 0 capture, 1 compare, 2 ovf1, 3 ovf0
  localparam int SRC_BIT [NSRC] = '{3, 6, 7, 1};
  localparam int SRC_VEC [NSRC] = '{3, 4, 5, 6};
  localparam logic [AW-1:0] ADDR_FLAG = 6'h38;
  localparam logic [AW-1:0] ADDR_MASK = 6'h39;
endpackage

// File: rtl/tirq_rst_sync.sv
module tirq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/tirq_mask.sv
module tirq_mask #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [N-1:0] wr_bits,
  output logic [N-1:0] mask
);
  logic [N-1:0] mask_q, mask_d;

  always_comb begin
    mask_d = mask_q;
    if (wr_en) mask_d = wr_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mask_q <= '0;
    else if (wr_en) mask_q <= mask_d;
  end

  assign mask = mask_q;
endmodule

// File: rtl/tirq_flags.sv
module tirq_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_ev,
  input  logic [N-1:0] clr_req,
  output logic [N-1:0] flags
);
  logic [N-1:0] flag_q, flag_d, flag_en;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_comb begin
      flag_en[i] = set_ev[i] | clr_req[i];
      flag_d[i]  = set_ev[i];          // set dominates a same-cycle clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q[i] <= 1'b0;
      else if (flag_en[i]) flag_q[i] <= flag_d[i];
    end
  end

  assign flags = flag_q;
endmodule

// File: rtl/tirq_arb.sv
module tirq_arb
  import tirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pending,
  output logic            req,
  output logic [VW-1:0]   vec
);
  logic          req_d, req_q;
  logic [VW-1:0] vec_d, vec_q;

  always_comb begin
    req_d = |pending;
    vec_d = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pending[i]) vec_d = VW'(SRC_VEC[i]);   // lowest index wins
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      vec_q <= '0;
    end else begin
      req_q <= req_d;
      vec_q <= vec_d;
    end
  end

  assign req = req_q;
  assign vec = vec_q;
endmodule

// File: rtl/tmr_irq_unit.sv
module tmr_irq_unit
  import tirq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] io_addr,
  input  logic          io_wr,
  input  logic [DW-1:0] io_wdata,
  output logic [DW-1:0] io_rdata,
  input  logic          ev_cap1,
  input  logic          ev_cmp1,
  input  logic          ev_ovf1,
  input  logic          ev_turn1,
  input  logic          ev_ovf0,
  input  logic          pwm_mode,
  input  logic          gie,
  input  logic          ack_valid,
  input  logic [VW-1:0] ack_vec,
  output logic          irq_req,
  output logic [VW-1:0] irq_vec
);
  logic            rst_int_n;
  logic            wr_flag, wr_mask;
  logic [NSRC-1:0] set_ev, clr_req, wr_bits;
  logic [NSRC-1:0] flags_q, mask_q, pending;
  logic [DW-1:0]   flag_byte, mask_byte;
  logic [DW-1:0]   used_bits;
  logic            unused_wdata;

  tirq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n));

  assign wr_flag = io_wr && (io_addr == ADDR_FLAG);
  assign wr_mask = io_wr && (io_addr == ADDR_MASK);

  always_comb begin
    set_ev[0] = ev_cap1;
    set_ev[1] = ev_cmp1;
    set_ev[2] = pwm_mode ? ev_turn1 : ev_ovf1;
    set_ev[3] = ev_ovf0;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign wr_bits[i] = io_wdata[SRC_BIT[i]];
    assign clr_req[i] = (wr_flag && io_wdata[SRC_BIT[i]]) ||
                        (ack_valid && (ack_vec == VW'(SRC_VEC[i])));
  end

  always_comb begin
    flag_byte = '0;
    mask_byte = '0;
    used_bits = '0;
    for (int i = 0; i < NSRC; i++) begin
      flag_byte[SRC_BIT[i]] = flags_q[i];
      mask_byte[SRC_BIT[i]] = mask_q[i];
      used_bits[SRC_BIT[i]] = 1'b1;
    end
  end

  assign unused_wdata = ^(io_wdata & ~used_bits);

  tirq_mask #(.N(NSRC)) u_mask (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_mask), .wr_bits(wr_bits), .mask(mask_q)
  );

  tirq_flags #(.N(NSRC)) u_flags (
    .clk(clk), .rst_n(rst_int_n), .set_ev(set_ev), .clr_req(clr_req), .flags(flags_q)
  );

  assign pending = flags_q & mask_q & {NSRC{gie}};

  tirq_arb u_arb (
    .clk(clk), .rst_n(rst_int_n), .pending(pending), .req(irq_req), .vec(irq_vec)
  );

  always_comb begin
    if (io_addr == ADDR_FLAG)      io_rdata = flag_byte;
    else if (io_addr == ADDR_MASK) io_rdata = mask_byte;
    else                           io_rdata = {DW{unused_wdata & 1'b0}};
  end
endmodule

// File: rtl/tirq_checker.sv
module tirq_checker
  import tirq_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [DW-1:0]   io_rdata,
  input logic            ev_cap1,
  input logic            ev_ovf0,
  input logic            gie,
  input logic            ack_valid,
  input logic [VW-1:0]   ack_vec,
  input logic            ev_cmp1,
  input logic [NSRC-1:0] flags,
  input logic [NSRC-1:0] mask,
  input logic            irq_req,
  input logic [VW-1:0]   irq_vec
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rdata & 8'h35) == 8'h00);                                          // R2
  AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && ev_cap1 |=> flags[0]);                                 // R10
  AST_OVF0_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && ev_ovf0 |=> flags[3]);                                 // R3
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flags[1] && ack_valid && ack_vec == 3'd4 && !ev_cmp1 |=> !flags[1]);   // R5
  AST_REQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && irq_req |-> $past(gie));                               // R6
  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec >= 3'd3 && irq_vec <= 3'd6));                     // R7
  AST_VEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> irq_vec == 3'd0);                                         // R11
  AST_REQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && irq_req |-> $past(|(flags & mask)));                   // R11
endmodule

bind tmr_irq_unit tirq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .io_rdata(io_rdata), .ev_cap1(ev_cap1),
  .ev_ovf0(ev_ovf0), .gie(gie), .ack_valid(ack_valid), .ack_vec(ack_vec),
  .ev_cmp1(ev_cmp1), .flags(flags_q), .mask(mask_q),
  .irq_req(irq_req), .irq_vec(irq_vec)
);

// File: tb/tmr_irq_unit_test.sv
module tmr_irq_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] io_addr = '0;
  logic       io_wr = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic       ev_cap1 = 0, ev_cmp1 = 0, ev_ovf1 = 0, ev_turn1 = 0, ev_ovf0 = 0;
  logic       pwm_mode = 0, gie = 0, ack_valid = 0;
  logic [2:0] ack_vec = '0;
  logic       irq_req;
  logic [2:0] irq_vec;

  int    n_vec = 0, n_bad = 0;
  bit    done = 0;
  string phase = "R1 reset";

  // behavioural reference state
  logic [7:0] m_mask, m_flag;
  logic       m_req;
  logic [2:0] m_vec;

  always #10 clk = ~clk;

  tmr_irq_unit uut (.*);

  function automatic int vec_of_bit(int b);
    case (b)
      3: return 3;
      6: return 4;
      7: return 5;
      1: return 6;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask = 8'h00; m_flag = 8'h00; m_req = 0; m_vec = 0;
    end else begin
      logic [7:0] pend, nf, setb;
      pend = m_flag & m_mask & {8{gie}};
      m_req = (pend != 0);
      m_vec = 0;
      if (pend[1]) m_vec = 6;
      if (pend[7]) m_vec = 5;
      if (pend[6]) m_vec = 4;
      if (pend[3]) m_vec = 3;
      setb = {(pwm_mode ? ev_turn1 : ev_ovf1), ev_cmp1, 2'b00, ev_cap1, 1'b0, ev_ovf0, 1'b0};
      nf = m_flag;
      foreach (nf[b]) begin
        if (vec_of_bit(b) != 0) begin
          if ((io_wr && io_addr == 6'h38 && io_wdata[b]) ||
              (ack_valid && int'(ack_vec) == vec_of_bit(b))) nf[b] = 1'b0;
          if (setb[b]) nf[b] = 1'b1;
        end
      end
      m_flag = nf;
      if (io_wr && io_addr == 6'h39) m_mask = io_wdata & 8'hCA;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      logic [7:0] exp_rd;
      exp_rd = (io_addr == 6'h38) ? m_flag : (io_addr == 6'h39) ? m_mask : 8'h00;
      n_vec++;
      if (io_rdata !== exp_rd) begin
        n_bad++;
        $display("FAIL %s: io_rdata=%h expected %h", phase, io_rdata, exp_rd);
      end
      if (irq_req !== m_req || irq_vec !== m_vec) begin
        n_bad++;
        $display("FAIL %s: req/vec=%0b/%0d expected %0b/%0d",
                 phase, irq_req, irq_vec, m_req, m_vec);
      end
    end
  end

  task automatic idle();
    io_wr = 0; ev_cap1 = 0; ev_cmp1 = 0; ev_ovf1 = 0; ev_turn1 = 0;
    ev_ovf0 = 0; ack_valid = 0;
  endtask

  task automatic step(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1; idle();
    end
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    io_addr = a; io_wr = 1; io_wdata = d;
    step();
  endtask

  task automatic ack(logic [2:0] v);
    ack_valid = 1; ack_vec = v;
    step();
  endtask

  initial begin
    #1;
    phase = "R1 reset"; io_addr = 6'h38; step(3);
    rst_n = 1; step(5); io_addr = 6'h39; step(2);

    phase = "R2 mask bits"; wr(6'h39, 8'hFF); step(2); wr(6'h39, 8'h00); step(1);
    wr(6'h39, 8'h35); step(1);

    phase = "R3 event sets"; io_addr = 6'h38;
    ev_cap1 = 1; step(); ev_cmp1 = 1; step(); ev_ovf1 = 1; step(); ev_ovf0 = 1; step(2);
    phase = "R3 write zero"; wr(6'h38, 8'h00); step(1);
    phase = "R4 w1c"; wr(6'h38, 8'h08); step(); wr(6'h38, 8'h82); step();
    wr(6'h38, 8'hFF); step();

    phase = "R6 gating"; ev_cap1 = 1; ev_ovf0 = 1; step();
    wr(6'h39, 8'hCA); step(2); gie = 1; step(3); gie = 0; step(2);
    wr(6'h39, 8'h02); gie = 1; step(3);

    phase = "R9 priority"; wr(6'h39, 8'hFF);
    ev_cmp1 = 1; ev_ovf1 = 1; step(3);
    phase = "R7 vectors"; ack(3); step(2); ack(4); step(2); ack(5); step(2); ack(6); step(3);

    phase = "R5 ack select"; ev_cap1 = 1; ev_cmp1 = 1; ev_ovf1 = 1; ev_ovf0 = 1; step(2);
    ack(4); step(); ack(0); step(); ack(7); step(); ack(2); step(2);
    wr(6'h38, 8'hFF); step();

    phase = "R8 pwm"; pwm_mode = 1; ev_ovf1 = 1; step(2); ev_turn1 = 1; step(2);
    wr(6'h38, 8'h80); pwm_mode = 0; ev_turn1 = 1; step(2); ev_ovf1 = 1; step(2);
    wr(6'h38, 8'hFF);

    phase = "R10 set wins"; ev_cap1 = 1; io_addr = 6'h38; io_wr = 1; io_wdata = 8'h08; step(2);
    ev_cmp1 = 1; ack_valid = 1; ack_vec = 3'd4; step(2);
    ev_ovf0 = 1; ack_valid = 1; ack_vec = 3'd6; step(2);

    phase = "R12 other addr"; wr(6'h20, 8'hFF); io_addr = 6'h20; step(2);
    wr(6'h3A, 8'hFF); io_addr = 6'h38; step(); io_addr = 6'h39; step();

    phase = "R11 R9 R10 mixed";
    for (int k = 0; k < 600; k++) begin
      logic [31:0] r;
      r = $urandom;
      ev_cap1 = r[0] & r[1]; ev_cmp1 = r[2] & r[3]; ev_ovf1 = r[4] & r[5];
      ev_turn1 = r[6] & r[7]; ev_ovf0 = r[8] & r[9]; pwm_mode = r[10];
      gie = r[11] | r[12];
      io_addr = r[13] ? 6'h38 : (r[14] ? 6'h39 : 6'h11);
      io_wr = r[15] & r[16]; io_wdata = r[24:17];
      ack_valid = r[25] & r[26]; ack_vec = r[29:27];
      @(negedge clk); #1;
    end
    idle(); step(3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1; n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule